// File: doc/BRIEF.md
# Multi-Read-Port Addressed Register RAM

A small register-based RAM with one write port and a parameterised number of independent read ports. Storage is split into addressed cells, numbered from 1 up to the cell count. Address value zero on any port means "no access", so a port that is idle simply holds its address at zero.

Writes are level-driven. While the write address names a cell, that cell follows the write data every cycle. When the address moves away, the cell keeps the word it saw in the last cycle it was addressed. Each read port registers the contents of the cell named by its own address, so a read takes one cycle and a write reaches a read port two cycles after it is applied. All read ports see the same stored contents. All ports may change every cycle.

Top module: `mrp_ram`

## Requirements
- R1: A read address applied in cycle t puts that cell's stored word on the port's read data in cycle t+1.
- R2: A write address and write data applied in cycle t appear on a read port held at that address in cycle t+2.
- R3: While the write address names a cell, the cell discards its old word and follows the write data every cycle.
- R4: After the write address leaves a cell, the cell keeps the write data of the last cycle in which it was addressed.
- R5: When a read and a write hit the same cell in the same cycle, the read port shows the old word in the next cycle and the new word from the cycle after onward.
- R6: Writes may change every cycle: writing (address 1, data 1), then (2, 2), then (1, 3) in consecutive cycles leaves cell 1 holding 3 and cell 2 holding 2.
- R7: Every read port decodes its own address independently and all read ports return the same stored contents.
- R8: A read address of 0, or above the cell count, drives zero on that read port one cycle later.
- R9: A write address of 0, or above the cell count, changes no cell.
- R10: A synchronous active-high reset clears every cell and every read data output to zero.
- R11: A data word of zero is stored like any other value; only the write address decides whether a write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr | input | AW | Write cell number, 0 = no write |
| wr_data | input | DW | Write data word |
| rd_addr | input | NRD*AW | Read cell numbers, port p in bits [p*AW +: AW], 0 = no read |
| rd_data | output | NRD*DW | Read data words, port p in bits [p*DW +: DW] |

## Verification
The hardest case to reach is a read and a write landing on the same cell in the same cycle while the write data keeps changing, because the old-then-new ordering only shows if the port stays on that cell for two more cycles. Directed steps hold a read port on the written cell across the write and the cycles after it, and a long stretch of random traffic with a small address range (including 0 and values above the cell count) makes such collisions frequent on all ports at once, compared every cycle against a behavioural model.

// File: rtl/mrp_pkg.sv
package mrp_pkg;

  // True when an address names a real cell (cells are numbered 1..ncell).
  function automatic logic addr_in_range(input int unsigned addr, input int unsigned ncell);
    return (addr >= 1) && (addr <= ncell);
  endfunction

  // Bit offset of a cell's word inside the flattened storage vector.
  function automatic int unsigned cell_offset(input int unsigned cell_num, input int unsigned dw);
    return (cell_num - 1) * dw;
  endfunction

endpackage

// File: rtl/mrp_cell.sv
module mrp_cell #(
  parameter int DW  = 8,
  parameter int AW  = 4,
  parameter int NUM = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cell_q,
  output logic          wr_hit
);

  assign wr_hit = (wr_addr == AW'(NUM));

  always_ff @(posedge clk) begin
    if (rst)         cell_q <= '0;
    else if (wr_hit) cell_q <= wr_data;
  end

  // R3: an addressed cell takes the presented word on the next edge
  p_track_r3: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (cell_q == $past(wr_data)));

  // R4 / R9: a cell not addressed keeps its word
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(cell_q));

endmodule

// File: rtl/mrp_rdport.sv
module mrp_rdport
  import mrp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 4,
  parameter int NCELL = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       rd_addr,
  input  logic [NCELL*DW-1:0] mem_flat,
  output logic [DW-1:0]       rd_q,
  output logic                rd_hit
);

  logic [DW-1:0] sel_word;

  assign rd_hit = addr_in_range(int'(rd_addr), NCELL);

  always_comb begin
    sel_word = '0;
    for (int c = 1; c <= NCELL; c++) begin
      if (rd_addr == AW'(c)) sel_word = mem_flat[cell_offset(c, DW) +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= sel_word;
  end

  // R8: a read that names no cell returns zero
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rd_q == '0));

  // R10: reset leaves the port output at zero
  p_reset_clear_r10: assert property (@(posedge clk)
    $past(rst) |-> (rd_q == '0));

endmodule

// File: rtl/mrp_ram.sv
module mrp_ram #(
  parameter int DW    = 8,
  parameter int NCELL = 6,
  parameter int NRD   = 3,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data
);

  localparam int MEMW = NCELL * DW;

  logic [MEMW-1:0]  mem_flat;
  logic [NCELL-1:0] wr_hit;
  logic [NRD-1:0]   rd_hit;

  genvar c, p;

  generate
    for (c = 0; c < NCELL; c++) begin : g_cell
      mrp_cell #(.DW(DW), .AW(AW), .NUM(c + 1)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cell_q  (mem_flat[c*DW +: DW]),
        .wr_hit  (wr_hit[c])
      );
    end
  endgenerate

  // R9: at most one cell is selected by any write address
  p_one_writer_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_hit));

  generate
    for (p = 0; p < NRD; p++) begin : g_port
      mrp_rdport #(.DW(DW), .AW(AW), .NCELL(NCELL)) u_port (
        .clk      (clk),
        .rst      (rst),
        .rd_addr  (rd_addr[p*AW +: AW]),
        .mem_flat (mem_flat),
        .rd_q     (rd_data[p*DW +: DW]),
        .rd_hit   (rd_hit[p])
      );

      for (c = 0; c < NCELL; c++) begin : g_chk
        // R1: one-cycle read of the stored word (old word on a collision, R5)
        p_read_lat_r1: assert property (@(posedge clk) disable iff (rst)
          (rd_addr[p*AW +: AW] == AW'(c + 1)) |=>
            (rd_data[p*DW +: DW] == $past(mem_flat[c*DW +: DW])));

        // R2: a write reaches a port held at that cell two cycles later
        p_write_lat_r2: assert property (@(posedge clk) disable iff (rst)
          ($past(wr_hit[c]) && !$past(rst) && (rd_addr[p*AW +: AW] == AW'(c + 1))) |=>
            (rd_data[p*DW +: DW] == $past(wr_data, 2)));
      end
    end
  endgenerate

endmodule

// File: tb/sim_mrp_ram.sv
`timescale 1ns/1ps
module sim_mrp_ram;

  localparam int DW = 8, NCELL = 6, NRD = 3, AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0]     wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD*DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_req = "R10";

  int ref_mem [1:NCELL];
  int exp_rd  [NRD];

  always #2 clk = ~clk;

  mrp_ram #(.DW(DW), .NCELL(NCELL), .NRD(NRD), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int port_out(input int p);
    return int'(rd_data[p*DW +: DW]);
  endfunction

  // Behavioural model: reads see the memory before this edge's write.
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= NCELL; i++) ref_mem[i] = 0;
      for (int p = 0; p < NRD; p++) exp_rd[p] = 0;
    end else begin
      for (int p = 0; p < NRD; p++) begin
        int a;
        a = int'(rd_addr[p*AW +: AW]);
        exp_rd[p] = (a >= 1 && a <= NCELL) ? ref_mem[a] : 0;
      end
      if (int'(wr_addr) >= 1 && int'(wr_addr) <= NCELL)
        ref_mem[int'(wr_addr)] = int'(wr_data);
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      for (int p = 0; p < NRD; p++) begin
        n_chk++;
        if (port_out(p) != exp_rd[p]) begin
          n_fail++;
          $display("FAIL %s model port %0d: got %0d expected %0d", cur_req, p, port_out(p), exp_rd[p]);
        end
      end
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input int wa, input int wd, input int r0, input int r1, input int r2);
    wr_addr = AW'(wa);
    wr_data = DW'(wd);
    rd_addr = {AW'(r2), AW'(r1), AW'(r0)};
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    cyc(0, 0, 1, 2, 3);
    chk("R10", port_out(0), 0); chk("R10", port_out(1), 0); chk("R10", port_out(2), 0);

    cur_req = "R3";
    cyc(2, 10, 2, 0, 0); chk("R5", port_out(0), 0);
    cyc(2, 11, 2, 0, 0); chk("R2", port_out(0), 10);
    cyc(2, 12, 2, 0, 0); chk("R3", port_out(0), 11);
    cyc(0, 99, 2, 0, 0); chk("R3", port_out(0), 12);
    cyc(0, 99, 2, 0, 0); chk("R4", port_out(0), 12);

    cur_req = "R6";
    cyc(1, 1, 0, 0, 0);
    cyc(2, 2, 0, 0, 0);
    cyc(1, 3, 0, 0, 0);
    cyc(0, 0, 1, 2, 0);
    chk("R6", port_out(0), 3); chk("R6", port_out(1), 2);

    cur_req = "R7";
    cyc(0, 0, 2, 1, 2);
    chk("R7", port_out(0), 2); chk("R7", port_out(1), 3); chk("R7", port_out(2), 2);

    cur_req = "R5";
    cyc(1, 7, 1, 1, 0); chk("R5", port_out(0), 3); chk("R5", port_out(1), 3);
    cyc(0, 0, 1, 0, 0); chk("R5", port_out(0), 7);

    cur_req = "R8";
    cyc(0, 0, 0, 7, 15);
    chk("R8", port_out(0), 0); chk("R8", port_out(1), 0); chk("R8", port_out(2), 0);

    cur_req = "R9";
    cyc(0, 55, 0, 0, 0);
    cyc(7, 55, 0, 0, 0);
    cyc(15, 55, 0, 0, 0);
    cyc(0, 0, 1, 2, 3);
    chk("R9", port_out(0), 7); chk("R9", port_out(1), 2); chk("R9", port_out(2), 0);

    cur_req = "R11";
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); chk("R11", port_out(0), 0);

    cur_req = "R7";
    for (int k = 0; k < 3000; k++)
      cyc($urandom_range(0, 9), $urandom_range(0, 255),
          $urandom_range(0, 9), $urandom_range(0, 9), $urandom_range(0, 9));

    cur_req = "R10";
    cyc(4, 200, 0, 0, 0);
    rst = 1'b1;
    cyc(0, 0, 4, 4, 4);
    rst = 1'b0;
    cyc(0, 0, 4, 1, 2);
    chk("R10", port_out(0), 0); chk("R10", port_out(1), 0); chk("R10", port_out(2), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule